// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that counts in its own slow clock domain and issues a reset pulse when software stops servicing it. Software controls it only by writing 16-bit key codes to a key register. One code starts the watchdog, which can then never be stopped except by a system reset. A second code refreshes the count. A third code opens the prescaler and reload registers for writing. Any other key write closes them again.

The configuration lives in the bus clock domain. Each start or refresh write takes a snapshot of the prescaler and reload values and sends a toggle event across a synchroniser into the watchdog clock domain. There a prescaled 12-bit down-counter runs. It raises `wd_rst` for one watchdog clock cycle when it expires, reloads, and keeps counting.

Top module: `iwdt_core`

## Requirements
- R1: After reset the prescaler reads 0, the reload register reads 0xFFF, the registers are locked, the watchdog is stopped, `wd_count` is 0xFFF and `wd_rst` is low.
- R2: A write of 0x5555 to `addr` 0 unlocks the registers. Only `wdata[15:0]` is compared as the key. When unlocked, `addr` 1 stores `wdata[2:0]` as the prescaler and `addr` 2 stores `wdata[11:0]` as the reload value. `rdata` returns each stored value zero-extended.
- R3: Writes to `addr` 1 or 2 while the registers are locked leave the stored values unchanged.
- R4: Any key write other than 0x5555 locks the registers again. This includes the refresh key 0xAAAA.
- R5: The key 0xCCCC starts the watchdog. `wd_count` then falls from 0xFFF by one every 4·2^prescaler watchdog clocks.
- R6: The key 0xAAAA loads the counter with the reload value captured at that write.
- R7: With no refresh, successive `wd_rst` pulses are exactly (4·2^prescaler)·reload watchdog clocks apart. A reload value of 0 behaves like 1.
- R8: `wd_rst` is high for exactly one watchdog clock. In that same cycle the counter takes the reload value, and counting goes on.
- R9: Once started, no register write stops the watchdog.
- R10: Refresh writes that come more often than the timeout keep `wd_rst` low.
- R11: New prescaler or reload values have no effect on the running count until the next start or refresh write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous system reset, both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wclk | input | 1 | Slow watchdog clock |
| wd_rst | output | 1 | One-cycle reset pulse on expiry (wclk domain) |
| wd_count | output | 12 | Current down-counter value (wclk domain) |

## Verification
A table of prescaler and reload pairs is used to measure the gap between successive pulses. The pairs include the smallest and largest divisors and reload values of 0 and 1, so an error in the divisor exponent can be told apart from an off-by-one in the terminal count. Separate key sequences check three cases: a protected write that is refused, a relock caused by a foreign key, and a relock caused by a refresh. The remaining checks contrast timely refreshes, which must suppress every pulse, with attempts to stop the watchdog, which must not. They also confirm that a reload change made without a refresh does not alter the running period.

// File: rtl/iwdt_core.sv
module iwdt_core #(
  parameter int CNT_W = 12,
  parameter int PR_W  = 3,
  parameter int SYNC  = 2,
  parameter logic [15:0] KEY_OPEN  = 16'h5555,
  parameter logic [15:0] KEY_FEED  = 16'hAAAA,
  parameter logic [15:0] KEY_START = 16'hCCCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             wclk,
  output logic             wd_rst,
  output logic [CNT_W-1:0] wd_count
);
  localparam int DW = (1 << PR_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [15:0]      key;
  logic             unlocked, en_q, rf_tgl;
  logic [PR_W-1:0]  pr_q, pr_snap, pr_w;
  logic [CNT_W-1:0] rl_q, rl_snap, rl_w, cnt_q;

  assign key = wdata[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      en_q     <= 1'b0;
      rf_tgl   <= 1'b0;
      pr_q     <= '0;
      rl_q     <= CNT_MAX;
      pr_snap  <= '0;
      rl_snap  <= CNT_MAX;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          unlocked <= (key == KEY_OPEN);
          if (key == KEY_START) en_q <= 1'b1;
          if (key == KEY_FEED) rf_tgl <= ~rf_tgl;
          if (key == KEY_FEED || key == KEY_START) begin
            pr_snap <= pr_q;
            rl_snap <= rl_q;
          end
        end
        2'd1: if (unlocked) pr_q <= wdata[PR_W-1:0];
        2'd2: if (unlocked) rl_q <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd1: rdata[PR_W-1:0]  = pr_q;
      2'd2: rdata[CNT_W-1:0] = rl_q;
      default: ;
    endcase
  end

  logic [SYNC-1:0] en_sync;
  logic [SYNC:0]   rf_sync;
  logic            en_run, en_d, rf_pulse, start_edge, tick;
  logic [DW-1:0]   div_q, div_last;
  logic [DW:0]     div_span;

  assign en_run     = en_sync[SYNC-1];
  assign start_edge = en_run & ~en_d;
  assign rf_pulse   = rf_sync[SYNC] ^ rf_sync[SYNC-1];
  assign div_span   = {{(DW-2){1'b0}}, 3'b100} << pr_w;
  assign div_last   = div_span[DW-1:0] - {{(DW-1){1'b0}}, 1'b1};
  assign tick       = (div_q == div_last);
  assign wd_count   = cnt_q;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      en_sync <= '0;
      rf_sync <= '0;
      en_d    <= 1'b0;
      pr_w    <= '0;
      rl_w    <= CNT_MAX;
      cnt_q   <= CNT_MAX;
      div_q   <= '0;
      wd_rst  <= 1'b0;
    end else begin
      en_sync <= {en_sync[SYNC-2:0], en_q};
      rf_sync <= {rf_sync[SYNC-1:0], rf_tgl};
      en_d    <= en_run;
      wd_rst  <= 1'b0;
      if (rf_pulse || start_edge) begin
        pr_w <= pr_snap;
        rl_w <= rl_snap;
      end
      if (!en_run) begin
        cnt_q <= CNT_MAX;
        div_q <= '0;
      end else if (rf_pulse) begin
        cnt_q <= rl_snap;
        div_q <= '0;
      end else if (tick) begin
        div_q <= '0;
        if (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
          cnt_q  <= rl_w;
          wd_rst <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/iwdt_core_chk.sv
module iwdt_core_chk #(
  parameter int CNT_W = 12,
  parameter int PR_W  = 3
) (
  input logic             clk,
  input logic             wclk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic             unlocked,
  input logic             en_q,
  input logic [PR_W-1:0]  pr_q,
  input logic [CNT_W-1:0] rl_q,
  input logic             en_run,
  input logic             wd_rst,
  input logic [CNT_W-1:0] wd_count
);
  p_locked_rl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !unlocked) |=> $stable(rl_q));
  p_locked_pr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !unlocked) |=> $stable(pr_q));
  p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[15:0] != 16'h5555) |=> !unlocked);
  p_sticky_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  p_single_pulse_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  p_idle_count_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    !en_run |-> (wd_count == '1 && !wd_rst));
endmodule

bind iwdt_core iwdt_core_chk #(.CNT_W(CNT_W), .PR_W(PR_W)) u_chk (
  .clk(clk), .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .unlocked(unlocked), .en_q(en_q), .pr_q(pr_q),
  .rl_q(rl_q), .en_run(en_run), .wd_rst(wd_rst), .wd_count(wd_count)
);

// File: tb/iwdt_core_test.sv
module iwdt_core_test;
  localparam int CLK_PERIOD  = 10;
  localparam int WCLK_PERIOD = 30;
  localparam int NVEC = 7;
  localparam logic [30:0] VEC [NVEC] = '{
    {3'd0, 12'd8, 16'd32},
    {3'd2, 12'd3, 16'd48},
    {3'd3, 12'd1, 16'd32},
    {3'd7, 12'd2, 16'd1024},
    {3'd0, 12'd1, 16'd4},
    {3'd1, 12'd0, 16'd8},
    {3'd1, 12'd5, 16'd40}
  };

  logic        clk = 0, wclk = 0, rst_n = 0, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        wd_rst;
  logic [11:0] wd_count;

  int tests = 0, fails = 0;
  int wcyc = 0, pulse_cnt = 0, last_pulse = 0, wide_err = 0;
  logic [11:0] cnt_at_pulse = 0;
  logic prev_rst = 0;

  iwdt_core uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wclk(wclk), .wd_rst(wd_rst), .wd_count(wd_count));

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always @(posedge wclk) wcyc++;
  always @(negedge wclk) begin
    if (wd_rst) begin
      pulse_cnt++;
      last_pulse = wcyc;
      cnt_at_pulse = wd_count;
      if (prev_rst) wide_err++;
    end
    prev_rst = wd_rst;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(string req, logic [1:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_pulse(output bit ok);
    int base = pulse_cnt;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge wclk);
      if (pulse_cnt > base) begin ok = 1; break; end
    end
  endtask

  task automatic interval(output int gap);
    bit ok1, ok2;
    int t0;
    wait_pulse(ok1); t0 = last_pulse;
    wait_pulse(ok2);
    gap = (ok1 && ok2) ? last_pulse - t0 : -1;
  endtask

  task automatic configure(logic [2:0] pr, logic [11:0] rl);
    bus_wr(0, 32'h5555); bus_wr(1, {29'd0, pr}); bus_wr(2, {20'd0, rl});
    bus_wr(0, 32'hAAAA);
    repeat (8) @(negedge wclk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int gap, base;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge wclk);
    // R1 reset state
    bus_rd("R1 prescaler", 1, 0);
    bus_rd("R1 reload", 2, 32'hFFF);
    chk("R1 count", {20'd0, wd_count}, 32'hFFF);
    chk("R1 wd_rst", {31'd0, wd_rst}, 0);
    // R3 locked writes ignored
    bus_wr(2, 32'h123); bus_rd("R3 reload locked", 2, 32'hFFF);
    bus_wr(1, 32'h5);   bus_rd("R3 prescaler locked", 1, 0);
    // R2 unlock and masking
    bus_wr(0, 32'hFFFF5555);
    bus_wr(2, 32'hFFFFF123); bus_rd("R2 reload masked", 2, 32'h123);
    bus_wr(1, 32'hFFFFFFFD); bus_rd("R2 prescaler masked", 1, 5);
    // R4 foreign key relocks
    bus_wr(0, 32'h1234); bus_wr(2, 32'h055);
    bus_rd("R4 foreign key relock", 2, 32'h123);
    // R4 refresh relocks
    bus_wr(0, 32'h5555); bus_wr(0, 32'hAAAA); bus_wr(2, 32'h066);
    bus_rd("R4 refresh relock", 2, 32'h123);
    // R5 start and count from 0xFFF
    bus_wr(0, 32'h5555); bus_wr(1, 0);
    bus_wr(0, 32'hCCCC);
    for (int i = 0; i < 50; i++) begin
      @(negedge wclk);
      if (wd_count != 12'hFFF) break;
    end
    chk("R5 first decrement", {20'd0, wd_count}, 32'hFFE);
    repeat (4) @(negedge wclk);
    chk("R5 prescaled step", {20'd0, wd_count}, 32'hFFD);
    // R6 R7 interval table
    for (int v = 0; v < NVEC; v++) begin
      configure(VEC[v][30:28], VEC[v][27:16]);
      interval(gap);
      chk($sformatf("R7 R6 interval pr=%0d rl=%0d", VEC[v][30:28], VEC[v][27:16]),
          gap, {16'd0, VEC[v][15:0]});
    end
    // R11 reload change without refresh has no effect
    bus_wr(0, 32'h5555); bus_wr(2, 50);
    interval(gap);
    chk("R11 unchanged period", gap, 40);
    bus_wr(0, 32'hAAAA);
    repeat (8) @(negedge wclk);
    interval(gap);
    chk("R11 period after refresh", gap, 400);
    // R8 pulse width and reload at expiry
    configure(0, 8);
    interval(gap);
    chk("R8 reload at pulse", {20'd0, cnt_at_pulse}, 8);
    chk("R8 single-cycle pulses", wide_err, 0);
    // R10 timely refresh suppresses pulses
    bus_wr(0, 32'hAAAA);
    repeat (6) @(negedge wclk);
    base = pulse_cnt;
    for (int i = 0; i < 30; i++) begin
      repeat (20) @(negedge wclk);
      bus_wr(0, 32'hAAAA);
    end
    chk("R10 no pulse while refreshed", pulse_cnt - base, 0);
    // R9 cannot be stopped
    bus_wr(0, 32'h0); bus_wr(0, 32'hFFFF); bus_wr(0, 32'h5555);
    bus_wr(0, 32'hCCCC); bus_wr(1, 0); bus_wr(2, 0);
    interval(gap);
    chk("R9 still running", gap, 32);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule